// File: doc/BRIEF.md
# Ripple-Carry ALU with Set-Less-Than

This block is a purely combinational 32-bit arithmetic logic unit. It is built from a row of one-bit slices. Each slice holds an AND gate, an OR gate and a full adder. A four-way multiplexer in each slice picks which of these drives that bit of the result. The carry passes from each slice to the next one up, so the adder is a plain ripple chain with no lookahead.

A 3-bit operation code selects AND, OR, add, subtract or set-less-than. Its top bit is a negate control. That control inverts every bit of the B operand and also feeds the carry into bit 0, which turns the adder into a two's-complement subtractor. For set-less-than, the slice at the most significant end exposes the sign of `a - b`. That sign is routed back into the spare multiplexer input of bit 0, and every other bit reads zero.

Three flags come out with the result:
- a zero flag, used for equality tests;
- a signed-overflow flag for add and subtract;
- the carry out of the top slice.

The block is meant to sit in the execute stage of a simple datapath, with its outputs registered by the surrounding logic.

Top module: `ripple_slt_alu`

## Requirements
- R1: Operation code 000 gives `result = a_in & b_in` bit by bit.
- R2: Operation code 001 gives `result = a_in | b_in` bit by bit.
- R3: Operation code 010 gives `result = (a_in + b_in) mod 2^32`.
- R4: Operation code 110 gives `result = (a_in - b_in) mod 2^32`, formed as `a_in + ~b_in + 1`.
- R5: Operation code 111 gives result bits 31..1 equal to 0, and bit 0 equal to bit 31 of `(a_in - b_in) mod 2^32`. This is the raw sign, not corrected for overflow.
- R6: `zero` is 1 exactly when all 32 bits of `result` are 0, for every operation code.
- R7: For codes 010 and 110, `overflow` is 1 exactly when the carry into bit 31 differs from the carry out of bit 31, which means a signed overflow of the add or subtract. For every other code `overflow` is 0.
- R8: For every code, `carry_out` is bit 32 of `a_in + B' + op_code[2]`. Here `B'` is `~b_in` when `op_code[2]` is 1 and `b_in` otherwise.
- R9: The undefined codes 011, 100 and 101 give a result of all zeros, so `zero` reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 32 | Operand A |
| b_in | input | 32 | Operand B |
| op_code | input | 3 | Operation select; bit 2 is the negate control |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |
| carry_out | output | 1 | Carry out of the most significant slice |

## Verification
The hardest case to reach is set-less-than when the subtraction overflows. In that case the raw sign routed to bit 0 disagrees with the true signed order. A closely related case is a carry that ripples through all 32 slices and changes the top slice's carry-in. Random operands almost never produce these. So directed vectors pair the most negative value with positive operands and the most positive value with negative ones, and use all-ones and zero operands for full-length carry propagation. Random vectors from a fixed seed then cover all eight codes, including the undefined ones.

// File: rtl/ralu_pkg.sv
package ralu_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  localparam logic [1:0] SEL_AND  = 2'd0;
  localparam logic [1:0] SEL_OR   = 2'd1;
  localparam logic [1:0] SEL_SUM  = 2'd2;
  localparam logic [1:0] SEL_LESS = 2'd3;

  // Carry out of a full adder: majority of its three inputs.
  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  // Sum output of a full adder.
  function automatic logic xor3(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  // True for the five defined operation codes.
  function automatic logic op_defined(input logic [2:0] code);
    case (code)
      OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT: return 1'b1;
      default:                               return 1'b0;
    endcase
  endfunction

  // True for codes whose overflow flag is meaningful.
  function automatic logic op_arith(input logic [2:0] code);
    return (code == OP_ADD) || (code == OP_SUB);
  endfunction

endpackage

// File: rtl/ralu_decode.sv
module ralu_decode
  import ralu_pkg::*;
(
  input  logic [2:0] op_code,
  output logic       bnegate,
  output logic [1:0] mux_sel,
  output logic       op_valid,
  output logic       arith_op
);

  always_comb begin
    bnegate  = op_code[2];
    mux_sel  = op_code[1:0];
    op_valid = op_defined(op_code);
    arith_op = op_arith(op_code);
  end

endmodule

// File: rtl/ralu_slice.sv
module ralu_slice
  import ralu_pkg::*;
#(
  parameter bit IS_MSB = 1'b0
)(
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       bnegate,
  input  logic       c_in,
  input  logic       less_in,
  input  logic [1:0] mux_sel,
  output logic       r_bit,
  output logic       c_out,
  output logic       set_out,
  output logic       ovf_out
);

  logic b_eff;
  logic sum_bit;

  always_comb begin
    b_eff   = bnegate ? ~b_bit : b_bit;
    sum_bit = xor3(a_bit, b_eff, c_in);
    c_out   = maj3(a_bit, b_eff, c_in);
    case (mux_sel)
      SEL_AND: r_bit = a_bit & b_eff;
      SEL_OR:  r_bit = a_bit | b_eff;
      SEL_SUM: r_bit = sum_bit;
      default: r_bit = less_in;
    endcase
  end

  // Only the top slice exposes its sign and overflow detection.
  generate
    if (IS_MSB) begin : g_top
      assign set_out = sum_bit;
      assign ovf_out = c_in ^ maj3(a_bit, b_eff, c_in);
    end else begin : g_plain
      assign set_out = 1'b0;
      assign ovf_out = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/ralu_zero_detect.sv
module ralu_zero_detect #(
  parameter int WIDTH = 32
)(
  input  logic [WIDTH-1:0] value,
  output logic             is_zero
);

  assign is_zero = ~(|value);

endmodule

// File: rtl/ripple_slt_alu.sv
module ripple_slt_alu #(
  parameter int WIDTH = 32
)(
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [2:0]       op_code,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carry_out
);

  localparam int MSB = WIDTH - 1;

  logic       bnegate;
  logic [1:0] mux_sel;
  logic       op_valid;
  logic       arith_op;

  // Named internal events, visible to the bound checker.
  logic             slt_sign;
  logic             msb_carry_in;
  logic             msb_carry_out;
  logic             msb_ovf;
  logic [WIDTH-1:0] raw_result;

  ralu_decode u_dec (
    .op_code  (op_code),
    .bnegate  (bnegate),
    .mux_sel  (mux_sel),
    .op_valid (op_valid),
    .arith_op (arith_op)
  );

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic c_in;
      logic c_out;
      logic r;
      logic set_o;
      logic ovf_o;

      if (i == 0) begin : g_cin0
        assign c_in = bnegate;
      end else begin : g_cinn
        assign c_in = g_bit[i-1].c_out;
      end

      ralu_slice #(.IS_MSB(i == MSB)) u_slice (
        .a_bit   (a_in[i]),
        .b_bit   (b_in[i]),
        .bnegate (bnegate),
        .c_in    (c_in),
        .less_in ((i == 0) ? slt_sign : 1'b0),
        .mux_sel (mux_sel),
        .r_bit   (r),
        .c_out   (c_out),
        .set_out (set_o),
        .ovf_out (ovf_o)
      );

      assign raw_result[i] = r;

      if (i == MSB) begin : g_msb_tap
        assign slt_sign      = set_o;
        assign msb_ovf       = ovf_o;
        assign msb_carry_in  = c_in;
        assign msb_carry_out = c_out;
      end
    end
  endgenerate

  assign result    = op_valid ? raw_result : '0;
  assign overflow  = arith_op & msb_ovf;
  assign carry_out = msb_carry_out;

  ralu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .value   (result),
    .is_zero (zero)
  );

endmodule

// File: rtl/ralu_checker.sv
module ralu_checker #(
  parameter int W = 32
)(
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [2:0]   op_code,
  input logic [W-1:0] result,
  input logic         zero,
  input logic         overflow,
  input logic         carry_out,
  input logic         msb_carry_in,
  input logic         slt_sign
);

  always_comb begin
    assert_and_R1: assert (op_code != 3'b000 || result == (a_in & b_in))
      else $error("AND result mismatch");
    assert_or_R2: assert (op_code != 3'b001 || result == (a_in | b_in))
      else $error("OR result mismatch");
    assert_slt_upper_R5: assert (op_code != 3'b111 || result[W-1:1] == '0)
      else $error("set-less-than upper bits not zero");
    assert_slt_bit0_R5: assert (op_code != 3'b111 || result[0] == slt_sign)
      else $error("set-less-than bit 0 differs from top sign");
    assert_zero_flag_R6: assert (zero == (result == '0))
      else $error("zero flag inconsistent with result");
    assert_no_overflow_R7: assert (op_code == 3'b010 || op_code == 3'b110 || !overflow)
      else $error("overflow raised outside add/sub");
    assert_overflow_rule_R7: assert (!(op_code == 3'b010 || op_code == 3'b110)
                                     || overflow == (msb_carry_in ^ carry_out))
      else $error("overflow differs from top carry comparison");
    assert_undefined_zero_R9: assert (!(op_code == 3'b011 || op_code == 3'b100 || op_code == 3'b101)
                                      || result == '0)
      else $error("undefined code produced nonzero result");
  end

endmodule

bind ripple_slt_alu ralu_checker #(.W(WIDTH)) u_chk (
  .a_in         (a_in),
  .b_in         (b_in),
  .op_code      (op_code),
  .result       (result),
  .zero         (zero),
  .overflow     (overflow),
  .carry_out    (carry_out),
  .msb_carry_in (msb_carry_in),
  .slt_sign     (slt_sign)
);

// File: tb/sim_ripple_slt_alu.sv
module sim_ripple_slt_alu;

  logic        clk = 1'b0;
  logic [31:0] a_in, b_in;
  logic [2:0]  op_code;
  logic [31:0] result;
  logic        zero, overflow, carry_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ripple_slt_alu u0 (
    .a_in(a_in), .b_in(b_in), .op_code(op_code),
    .result(result), .zero(zero), .overflow(overflow), .carry_out(carry_out)
  );

  // Expected result from the requirements (R1..R5, R9).
  function automatic logic [31:0] exp_result(input logic [31:0] a, input logic [31:0] b,
                                             input logic [2:0] op);
    logic [31:0] d;
    d = a - b;
    case (op)
      3'b000:  return a & b;
      3'b001:  return a | b;
      3'b010:  return a + b;
      3'b110:  return d;
      3'b111:  return {31'd0, d[31]};
      default: return 32'd0;
    endcase
  endfunction

  // R7: signed overflow by operand and result signs.
  function automatic logic exp_ovf(input logic [31:0] a, input logic [31:0] b,
                                   input logic [2:0] op);
    logic [31:0] s;
    if (op == 3'b010) begin
      s = a + b;
      return (a[31] == b[31]) && (s[31] != a[31]);
    end
    if (op == 3'b110) begin
      s = a - b;
      return (a[31] != b[31]) && (s[31] != a[31]);
    end
    return 1'b0;
  endfunction

  // R8: carry from a 33-bit sum.
  function automatic logic exp_carry(input logic [31:0] a, input logic [31:0] b,
                                     input logic [2:0] op);
    logic [32:0] s;
    logic [31:0] bb;
    bb = op[2] ? ~b : b;
    s = {1'b0, a} + {1'b0, bb} + {32'd0, op[2]};
    return s[32];
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b110:  return "R4";
      3'b111:  return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
    logic [31:0] er;
    @(posedge clk);
    a_in = a; b_in = b; op_code = op;
    @(negedge clk);
    er = exp_result(a, b, op);
    check(req_of(op), "result", result, er);
    check("R6", "zero", {31'd0, zero}, {31'd0, (er == 32'd0)});
    check("R7", "overflow", {31'd0, overflow}, {31'd0, exp_ovf(a, b, op)});
    check("R8", "carry_out", {31'd0, carry_out}, {31'd0, exp_carry(a, b, op)});
  endtask

  initial begin
    a_in = '0; b_in = '0; op_code = 3'b000;
    @(negedge clk);
    // Idle state with AND of zeros: result zero, flag set (R1, R6).
    check("R1", "idle result", result, 32'd0);
    check("R6", "idle zero", {31'd0, zero}, 32'd1);

    // Directed corners.
    run(32'hFFFF_FFFF, 32'h0000_0001, 3'b010); // R3 full carry ripple, R8
    run(32'h7FFF_FFFF, 32'h0000_0001, 3'b010); // R7 positive overflow
    run(32'h8000_0000, 32'h8000_0000, 3'b010); // R7 negative overflow, R6
    run(32'h8000_0000, 32'h0000_0001, 3'b110); // R4, R7 sub overflow
    run(32'h1234_5678, 32'h1234_5678, 3'b110); // R6 equality
    run(32'h0000_0000, 32'h0000_0000, 3'b110); // R8 carry out on 0-0
    run(32'h8000_0000, 32'h0000_0001, 3'b111); // R5 overflowed sign gives 0
    run(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111); // R5 overflowed sign gives 1
    run(32'hFFFF_FFFF, 32'h0000_0001, 3'b111); // R5 -1 < 1
    run(32'h0000_0005, 32'h0000_0005, 3'b111); // R5 equal gives 0
    run(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'b000); // R1
    run(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'b001); // R2
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011); // R9
    run(32'hFFFF_FFFF, 32'h0000_0000, 3'b100); // R9
    run(32'hFFFF_FFFF, 32'h0000_0000, 3'b101); // R9

    // Random vectors from a fixed seed over all codes.
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] ra, rb;
      logic [2:0]  rop;
      ra = $urandom();
      rb = $urandom();
      rop = 3'($urandom_range(7, 0));
      if (k % 5 == 0) rb = ra;
      if (k % 7 == 0) ra = {ra[31], 31'h7FFF_FFFF ^ {31{ra[0]}}};
      run(ra, rb, rop);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule